// File: doc/BRIEF.md
# Nested Interrupt Hold-Level Tracker

This block keeps the nesting state of an interrupt controller that uses eight priority levels, encoded in 3 bits. Level 0 is the highest priority, level 6 is the lowest level a service routine can run at, and level 7 stands for the main program. When nesting is enabled and a running routine is preempted by a request of higher priority, the block records the interrupted level in a 7-bit hold map. On each interrupt return it releases the most urgent held level and reports which level execution resumes at.

The block also owns the top-level interrupt. A select bit picks the source of that interrupt: the watchdog end-of-count pulse, or an external NMI pin. The pin is synchronised and edge-detected with a selectable polarity. Either source sets a pending flag, and an acknowledge strobe clears it. The top-level request obeys the global and top-level enables until software sets a write-once lock. After that, only a hardware reset can make the request maskable again.

Top module: `nest_hold_tracker`

## Requirements
- R1: After reset the control readback `ctl_rdata` is 8'h00, `tl_pend` and `tl_req` are 0, and `rest_lvl` is 7.
- R2: On a `preempt` strobe, hold bit `cur_lvl` (readback bit `cur_lvl`) becomes 1 on the next clock edge, but only when all of these hold: `nest_mode` is 1, `preempt_top` is 0, `cur_lvl` is below 7, and `preempt_lvl` is numerically lower than `cur_lvl`. Otherwise the hold map is unchanged.
- R3: An `iret` strobe clears the lowest-numbered set hold bit on the next clock edge. When no hold bit is set, it has no effect.
- R4: `rest_lvl` always equals the index of the lowest-numbered set hold bit, or 7 when the hold map is empty.
- R5: A control write (`ctl_wr`) with `ctl_wdata[7]`=1 sets the lock flag (readback bit 7). A write with bit 7 at 0 never clears it; only reset does.
- R6: Bits 6:0 of a control write are ignored: the hold map is unchanged by any write.
- R7: While the lock flag is 0, `tl_req` = `tl_pend` AND `ien` AND `tl_en` (combinational).
- R8: While the lock flag is 1, `tl_req` = `tl_pend`, whatever `ien` and `tl_en` are.
- R9: The NMI pin passes through two synchronising flops before edge detection. `nmi_rise`=1 selects the rising edge and 0 selects the falling edge. With the NMI source selected, `tl_pend` becomes 1 at the third rising clock edge after the pin changes. An edge of the other polarity is ignored.
- R10: `tl_src_nmi`=0 selects the watchdog: a `wdg_eoc` pulse sets `tl_pend` at the next edge, and NMI edges are ignored. `tl_src_nmi`=1 selects the NMI pin, and `wdg_eoc` is ignored.
- R11: `tl_ack` clears `tl_pend` at the next edge. When a source event occurs in the same cycle as `tl_ack`, `tl_pend` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| nest_mode | input | 1 | Nested interrupt mode enable |
| cur_lvl | input | 3 | Level currently executing (7 = main program) |
| preempt | input | 1 | Preemption event strobe |
| preempt_lvl | input | 3 | Level of the preempting request |
| preempt_top | input | 1 | Preemption comes from the top-level interrupt |
| iret | input | 1 | Interrupt return strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 7 = lock) |
| ien | input | 1 | Global interrupt enable |
| tl_en | input | 1 | Top-level interrupt enable |
| tl_src_nmi | input | 1 | Top-level source: 1 = NMI pin, 0 = watchdog |
| nmi_rise | input | 1 | NMI edge: 1 = rising, 0 = falling |
| nmi_pin | input | 1 | Asynchronous NMI input |
| wdg_eoc | input | 1 | Watchdog end-of-count pulse |
| tl_ack | input | 1 | Top-level pending acknowledge |
| ctl_rdata | output | 8 | Readback: {lock, hold[6:0]} |
| rest_lvl | output | 3 | Level an interrupt return resumes (7 = main) |
| tl_pend | output | 1 | Top-level pending flag |
| tl_req | output | 1 | Top-level interrupt request |

## Verification
The bound checker watches several invariants on every cycle:
- The lock flag is sticky.
- The hold map never gains a bit while nesting is off.
- The hold map holds still unless there is a preempt or return.
- A return removes exactly one held level.
- The restored level reads 7 exactly when the map is empty.
- The top-level request is consistent with the pending flag and the lock.

Other behaviour can only be shown by the directed scenarios, because each needs an exact cycle count or a specific ordering:
- the three-edge latency of the NMI path;
- which polarity and which source actually set the pending flag;
- which particular bit each preemption marks;
- the set-over-acknowledge ordering.

// File: rtl/nest_hold_tracker.sv
module nest_hold_tracker #(
  parameter int LVL_W = 3,
  localparam int NLVL = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nest_mode,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             preempt,
  input  logic [LVL_W-1:0] preempt_lvl,
  input  logic             preempt_top,
  input  logic             iret,
  input  logic             ctl_wr,
  input  logic [NLVL:0]    ctl_wdata,
  input  logic             ien,
  input  logic             tl_en,
  input  logic             tl_src_nmi,
  input  logic             nmi_rise,
  input  logic             nmi_pin,
  input  logic             wdg_eoc,
  input  logic             tl_ack,
  output logic [NLVL:0]    ctl_rdata,
  output logic [LVL_W-1:0] rest_lvl,
  output logic             tl_pend,
  output logic             tl_req
);
  localparam logic [LVL_W-1:0] MAIN = LVL_W'(NLVL);

  logic [NLVL-1:0] hold_q, set_vec, clr_vec;
  logic            lock_q;
  logic [2:0]      nmi_sync;
  logic            nmi_edge, tl_event, do_hold;

  assign do_hold = nest_mode && preempt && !preempt_top &&
                   (cur_lvl != MAIN) && (preempt_lvl < cur_lvl);
  assign set_vec = do_hold ? (NLVL'(1) << cur_lvl) : '0;
  assign clr_vec = iret ? (hold_q & (~hold_q + NLVL'(1))) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= '0;
    else        hold_q <= (hold_q & ~clr_vec) | set_vec;

  always_comb begin
    rest_lvl = MAIN;
    for (int i = NLVL - 1; i >= 0; i--)
      if (hold_q[i]) rest_lvl = LVL_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        lock_q <= 1'b0;
    else if (ctl_wr && ctl_wdata[NLVL]) lock_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nmi_sync <= '0;
    else        nmi_sync <= {nmi_sync[1:0], nmi_pin};

  assign nmi_edge = nmi_rise ? (nmi_sync[1] & ~nmi_sync[2])
                             : (~nmi_sync[1] & nmi_sync[2]);
  assign tl_event = tl_src_nmi ? nmi_edge : wdg_eoc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        tl_pend <= 1'b0;
    else if (tl_event) tl_pend <= 1'b1;
    else if (tl_ack)   tl_pend <= 1'b0;

  assign tl_req    = tl_pend && (lock_q || (ien && tl_en));
  assign ctl_rdata = {lock_q, hold_q};
endmodule

module nest_hold_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nest_mode,
  input logic       preempt,
  input logic       iret,
  input logic [7:0] ctl_rdata,
  input logic [2:0] rest_lvl,
  input logic       tl_pend,
  input logic       tl_req
);
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7] |=> ctl_rdata[7]);
  // R2
  flat_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nest_mode |=> ((ctl_rdata[6:0] & ~$past(ctl_rdata[6:0])) == 7'd0));
  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!preempt && !iret) |=> $stable(ctl_rdata[6:0]));
  // R3
  iret_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iret && !preempt && ctl_rdata[6:0] != 7'd0) |=>
      ($countones(ctl_rdata[6:0]) == $countones($past(ctl_rdata[6:0])) - 1));
  // R4
  rest_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6:0] == 7'd0) == (rest_lvl == 3'd7));
  // R7
  req_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tl_req |-> tl_pend);
  // R8
  locked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tl_pend && ctl_rdata[7]) |-> tl_req);
endmodule

bind nest_hold_tracker nest_hold_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nest_mode(nest_mode), .preempt(preempt),
  .iret(iret), .ctl_rdata(ctl_rdata), .rest_lvl(rest_lvl),
  .tl_pend(tl_pend), .tl_req(tl_req)
);

// File: tb/tb_nest_hold_tracker.sv
module tb_nest_hold_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic nest_mode = 0, preempt = 0, preempt_top = 0, iret = 0, ctl_wr = 0;
  logic [2:0] cur_lvl = 3'd7, preempt_lvl = 3'd0;
  logic [7:0] ctl_wdata = 8'h00;
  logic ien = 0, tl_en = 0, tl_src_nmi = 0, nmi_rise = 1, nmi_pin = 0;
  logic wdg_eoc = 0, tl_ack = 0;
  logic [7:0] ctl_rdata;
  logic [2:0] rest_lvl;
  logic tl_pend, tl_req;
  int checks = 0, fails = 0, cycles = 0;

  nest_hold_tracker dut (
    .clk(clk), .rst_n(rst_n), .nest_mode(nest_mode), .cur_lvl(cur_lvl),
    .preempt(preempt), .preempt_lvl(preempt_lvl), .preempt_top(preempt_top),
    .iret(iret), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ien(ien),
    .tl_en(tl_en), .tl_src_nmi(tl_src_nmi), .nmi_rise(nmi_rise),
    .nmi_pin(nmi_pin), .wdg_eoc(wdg_eoc), .tl_ack(tl_ack),
    .ctl_rdata(ctl_rdata), .rest_lvl(rest_lvl), .tl_pend(tl_pend), .tl_req(tl_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles, expected < 5000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_preempt(logic [2:0] cur, logic [2:0] nl, logic top);
    cur_lvl = cur; preempt_lvl = nl; preempt_top = top; preempt = 1;
    step(); preempt = 0; preempt_top = 0;
  endtask

  task automatic do_iret();
    iret = 1; step(); iret = 0;
  endtask

  task automatic do_write(logic [7:0] d);
    ctl_wdata = d; ctl_wr = 1; step(); ctl_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 ctl_rdata", ctl_rdata, 8'h00);
    chk("R1 tl_pend", tl_pend, 0);
    chk("R1 tl_req", tl_req, 0);
    chk("R1 rest_lvl", rest_lvl, 7);
  endtask

  task automatic t_nesting();
    nest_mode = 1;
    do_preempt(3'd5, 3'd2, 0);
    chk("R2 hold after 5->2", ctl_rdata, 8'h20);
    chk("R4 rest level 5", rest_lvl, 5);
    do_preempt(3'd2, 3'd0, 0);
    chk("R2 hold after 2->0", ctl_rdata, 8'h24);
    chk("R4 rest level 2", rest_lvl, 2);
    nest_mode = 0;
    do_preempt(3'd4, 3'd1, 0);
    chk("R2 flat mode no hold", ctl_rdata, 8'h24);
    nest_mode = 1;
    do_preempt(3'd3, 3'd6, 0);
    chk("R2 lower priority no hold", ctl_rdata, 8'h24);
    do_preempt(3'd3, 3'd0, 1);
    chk("R2 top-level no hold", ctl_rdata, 8'h24);
    do_preempt(3'd7, 3'd1, 0);
    chk("R2 main program no hold", ctl_rdata, 8'h24);
    do_iret();
    chk("R3 iret clears bit2", ctl_rdata, 8'h20);
    chk("R4 rest level back to 5", rest_lvl, 5);
    do_iret();
    chk("R3 iret clears bit5", ctl_rdata, 8'h00);
    chk("R4 rest main", rest_lvl, 7);
    do_iret();
    chk("R3 iret on empty map", ctl_rdata, 8'h00);
  endtask

  task automatic t_write_ignore();
    do_preempt(3'd1, 3'd0, 0);
    chk("R2 hold bit1", ctl_rdata, 8'h02);
    do_write(8'h00);
    chk("R6 write 00 keeps hold", ctl_rdata, 8'h02);
    do_write(8'h7D);
    chk("R6 write 7D keeps hold", ctl_rdata, 8'h02);
    do_iret();
    chk("R3 hold cleared", ctl_rdata, 8'h00);
  endtask

  task automatic t_mask();
    tl_src_nmi = 0; ien = 0; tl_en = 1;
    wdg_eoc = 1; step(); wdg_eoc = 0;
    chk("R10 wdg sets pending", tl_pend, 1);
    chk("R7 ien=0 masks", tl_req, 0);
    ien = 1; #1;
    chk("R7 both enables", tl_req, 1);
    tl_en = 0; #1;
    chk("R7 tl_en=0 masks", tl_req, 0);
  endtask

  task automatic t_ack();
    tl_ack = 1; wdg_eoc = 1; step(); wdg_eoc = 0;
    chk("R11 set wins over ack", tl_pend, 1);
    step();
    chk("R11 ack clears", tl_pend, 0);
    tl_ack = 0;
  endtask

  task automatic t_nmi();
    tl_src_nmi = 1; nmi_rise = 1;
    wdg_eoc = 1; step(); wdg_eoc = 0;
    chk("R10 wdg ignored when NMI selected", tl_pend, 0);
    nmi_pin = 1; step(2);
    chk("R9 not yet pending after 2 edges", tl_pend, 0);
    step();
    chk("R9 rising edge pending at 3rd edge", tl_pend, 1);
    tl_ack = 1; step(); tl_ack = 0;
    nmi_pin = 0; step(4);
    chk("R9 falling ignored in rising mode", tl_pend, 0);
    nmi_rise = 0;
    nmi_pin = 1; step(4);
    chk("R9 rising ignored in falling mode", tl_pend, 0);
    nmi_pin = 0; step(3);
    chk("R9 falling edge pending", tl_pend, 1);
    tl_ack = 1; step(); tl_ack = 0;
    tl_src_nmi = 0; nmi_pin = 1; step(4); nmi_pin = 0; step(4);
    chk("R10 NMI ignored when watchdog selected", tl_pend, 0);
  endtask

  task automatic t_lock();
    do_write(8'h80);
    chk("R5 lock set", ctl_rdata, 8'h80);
    ien = 0; tl_en = 0;
    wdg_eoc = 1; step(); wdg_eoc = 0;
    chk("R8 locked request ignores enables", tl_req, 1);
    do_write(8'h00);
    chk("R5 lock not cleared by write", ctl_rdata[7], 1);
    rst_n = 0; step(); rst_n = 1; step();
    chk("R5 reset clears lock", ctl_rdata, 8'h00);
  endtask

  initial begin
    step(2); rst_n = 1; step();
    t_reset();
    t_nesting();
    t_write_ignore();
    t_mask();
    t_ack();
    t_nmi();
    t_lock();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule